// File: doc/BRIEF.md
# Adjustable One-Hour Countdown Timer

This block is the core of a kitchen-style interval timer. The user sets an alarm interval of 1 to 60 minutes with separate raise and lower controls, and then starts a run. While the run is active, the block counts slow time-base ticks. The alarm line goes high when the elapsed count reaches the interval. The interval decides when the alarm begins; it does not decide how long the alarm lasts. The alarm stays on until the user presses stop or the block is reset.

A tick-enable input carries the time base. In a real system it pulses once per minute. In simulation it can be high on every cycle, so that a full hour takes 60 clocks. The elapsed count is brought out so that it can be observed. Debouncing, display, sound and the divider that makes the minute tick all live outside this block.

Top module: `interval_timer`

## Requirements
- R1: An asynchronous active-high reset clears the alarm, the elapsed count and the run state at once, and returns the interval to 60.
- R2: A rising edge on start, while the block is idle (not running and alarm low), begins a run from an elapsed count of zero. Holding start high begins exactly one run and never restarts the count.
- R3: The elapsed count rises by exactly one on each clock edge where the run is active and tick is high. On every other edge it holds.
- R4: On the edge where the elapsed count reaches the interval, alarm goes high and counting freezes. Alarm then stays high, and the count stays put, until stop or reset.
- R5: Stop is level-sensitive. On any edge where it is high, it ends the run, clears the elapsed count to zero and drops the alarm. When stop and a start edge come in the same cycle, stop wins.
- R6: A rising edge on up raises the interval by one, and a rising edge on down lowers it by one. The interval saturates at 1 and at 60. Simultaneous up and down edges leave it unchanged.
- R7: Interval adjustments take effect only while the block is idle. Up or down edges during a run, or while the alarm is on, are ignored.
- R8: A start edge while the alarm is on is ignored. The alarm and the count stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | Start control, acts on its rising edge |
| stop | input | 1 | Stop control, level-sensitive, overrides start |
| up | input | 1 | Raise the interval by one, acts on its rising edge |
| down | input | 1 | Lower the interval by one, acts on its rising edge |
| tick | input | 1 | Time-base enable, one pulse per minute in use |
| alarm | output | 1 | High from the moment the interval is reached until stop or reset |
| elapsed | output | 6 | Ticks counted in the current run |

## Verification
The interval register has no port of its own. A wrong interval therefore shows up only as an alarm that rises on the wrong tick, so every run checks the alarm against a model interval on the exact edge it should fire. A bad run state or a bad edge detector shows at `elapsed` one cycle after the faulty edge. Examples are a count that moves without tick, a count that returns to zero while start is held, or a count that freezes late. The bench compares both outputs on every cycle, so any divergence is reported within the cycle it appears.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int MAX_TICKS = 60,
  localparam int CW = $clog2(MAX_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop,
  input  logic          up,
  input  logic          down,
  input  logic          tick,
  output logic          alarm,
  output logic [CW-1:0] elapsed
);

  localparam logic [CW-1:0] TOP = CW'(MAX_TICKS);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic          running, alarm_q;
  logic [CW-1:0] cnt, preset, cnt_nx;
  logic          start_d, up_d, down_d;
  logic          start_rise, up_rise, down_rise, idle;

  assign start_rise = start & ~start_d;
  assign up_rise    = up & ~up_d;
  assign down_rise  = down & ~down_d;
  assign idle       = ~running & ~alarm_q;
  assign cnt_nx     = cnt + ONE;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      start_d <= 1'b0;
      up_d    <= 1'b0;
      down_d  <= 1'b0;
    end else begin
      start_d <= start;
      up_d    <= up;
      down_d  <= down;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      running <= 1'b0;
      alarm_q <= 1'b0;
      cnt     <= '0;
    end else if (stop) begin
      running <= 1'b0;
      alarm_q <= 1'b0;
      cnt     <= '0;
    end else if (start_rise && idle) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running && tick) begin
      cnt <= cnt_nx;
      if (cnt_nx == preset) begin
        alarm_q <= 1'b1;
        running <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) preset <= TOP;
    else if (idle && !stop && (up_rise ^ down_rise)) begin
      if (up_rise && preset != TOP) preset <= preset + ONE;
      else if (down_rise && preset != ONE) preset <= preset - ONE;
    end
  end

  assign alarm   = alarm_q;
  assign elapsed = cnt;

  p_alarm_hold_r4: assert property (@(posedge clk) disable iff (rst)
    alarm && !stop |=> alarm);
  p_alarm_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    alarm && !stop |=> $stable(elapsed));
  p_stop_clears_r5: assert property (@(posedge clk) disable iff (rst)
    stop |=> !alarm && elapsed == '0);
  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
    running && !tick && !stop |=> $stable(elapsed));
  p_preset_range_r6: assert property (@(posedge clk) disable iff (rst)
    preset >= ONE && preset <= TOP);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    elapsed <= preset);
  p_run_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(preset));

endmodule

// File: tb/test_interval_timer.sv
module test_interval_timer;
  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, stop = 0, up = 0, down = 0, tick = 0;
  logic alarm;
  logic [5:0] elapsed;
  int checks = 0, errors = 0;
  bit done = 0;

  bit m_run, m_alarm, m_sd, m_ud, m_dd;
  int m_cnt, m_preset;
  string tag = "R1";

  always #5 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .up(up),
    .down(down), .tick(tick), .alarm(alarm), .elapsed(elapsed));

  task automatic model_reset();
    m_run = 0; m_alarm = 0; m_cnt = 0; m_preset = 60;
    m_sd = 0; m_ud = 0; m_dd = 0;
  endtask

  task automatic model_edge();
    bit idle_old, sr, ur, dr;
    idle_old = !m_run && !m_alarm;
    sr = start && !m_sd; ur = up && !m_ud; dr = down && !m_dd;
    if (idle_old && !stop && (ur != dr)) begin
      if (ur && m_preset < 60) m_preset++;
      else if (dr && m_preset > 1) m_preset--;
    end
    if (stop) begin m_run = 0; m_alarm = 0; m_cnt = 0; end
    else if (sr && idle_old) begin m_run = 1; m_cnt = 0; end
    else if (m_run && tick) begin
      m_cnt++;
      if (m_cnt == m_preset) begin m_alarm = 1; m_run = 0; end
    end
    m_sd = start; m_ud = up; m_dd = down;
  endtask

  task automatic compare();
    checks++;
    if (alarm !== m_alarm) begin
      errors++;
      $display("FAIL %s alarm actual %0b expected %0b", tag, alarm, m_alarm);
    end
    checks++;
    if (int'(elapsed) != m_cnt) begin
      errors++;
      $display("FAIL %s elapsed actual %0d expected %0d", tag, elapsed, m_cnt);
    end
  endtask

  task automatic step(input string t, input bit s, p, u, d, k);
    @(negedge clk);
    compare();
    tag = t;
    start = s; stop = p; up = u; down = d; tick = k;
    @(posedge clk);
    model_edge();
  endtask

  task automatic pulse_start(input string t);
    step(t, 1, 0, 0, 0, 0);
    step(t, 0, 0, 0, 0, 0);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare();
    rst = 0;
    // R1: default interval is 60, full run of 60 ticks
    pulse_start("R1");
    for (int i = 0; i < 62; i++) step("R1", 0, 0, 0, 0, 1);
    step("R5", 0, 1, 0, 0, 0);
    // R6: saturate down to 1, then run one tick
    for (int i = 0; i < 64; i++) begin
      step("R6", 0, 0, 0, 1, 0);
      step("R6", 0, 0, 0, 0, 0);
    end
    pulse_start("R6");
    step("R6", 0, 0, 0, 0, 1);
    step("R6", 0, 0, 0, 0, 1);
    step("R5", 0, 1, 0, 0, 0);
    // R6: saturate up at 60
    for (int i = 0; i < 63; i++) begin
      step("R6", 0, 0, 1, 0, 0);
      step("R6", 0, 0, 0, 0, 0);
    end
    step("R6", 0, 0, 1, 1, 0);
    step("R6", 0, 0, 0, 0, 0);
    for (int i = 0; i < 55; i++) begin
      step("R6", 0, 0, 0, 1, 0);
      step("R6", 0, 0, 0, 0, 0);
    end
    // R2: start held high, gated ticks (R3)
    for (int i = 0; i < 12; i++) step("R2", 1, 0, 0, 0, i % 3 == 0);
    // R7: adjustments during run ignored
    for (int i = 0; i < 6; i++) begin
      step("R7", 0, 0, 1, 0, 0);
      step("R7", 0, 0, 0, 0, 1);
    end
    // R8: start during alarm ignored; R4: ticks after alarm
    for (int i = 0; i < 4; i++) begin
      step("R8", 1, 0, 0, 0, 1);
      step("R8", 0, 0, 0, 0, 1);
    end
    // R7: adjust while alarm on ignored
    step("R7", 0, 0, 0, 1, 0);
    step("R7", 0, 0, 0, 0, 0);
    // R5: stop and start in the same cycle
    step("R5", 1, 1, 0, 0, 1);
    step("R5", 0, 0, 0, 0, 1);
    // R1: asynchronous reset mid-run
    pulse_start("R1");
    step("R1", 0, 0, 0, 0, 1);
    step("R1", 0, 0, 0, 0, 1);
    @(negedge clk);
    compare();
    #1 rst = 1; model_reset();
    #1 tag = "R1"; compare();
    @(negedge clk); rst = 0;
    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 5000; i++)
      step("R3", ($urandom % 5) == 0, ($urandom % 60) == 0,
           ($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 2) == 0);
    @(negedge clk);
    compare();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule